// File: doc/BRIEF.md
# E1 Timeslot-16 Channel-Associated Signaling Inserter

This block sits in the transmit path of an E1 framer. It places channel-associated signaling into timeslot 16 of the outgoing stream. The stream enters one timeslot byte per valid cycle. A frame strobe marks timeslot 0 of every frame, and a multiframe strobe marks timeslot 0 of frame 0 in each 16-frame multiframe. The block tracks the timeslot and frame position from these strobes. Every byte leaves exactly one cycle after it enters. Only timeslot 16 can be changed.

A host fills sixteen signaling registers through a simple register bus. On each multiframe boundary the block copies all sixteen registers into an internal snapshot. During the multiframe that follows, frame f carries snapshot byte f in timeslot 16. A sticky status flag tells the host that a new multiframe has started, so it has one multiframe period to write fresh values. If it writes nothing, the same values go out again. Frame 0 always carries the multiframe alignment word in its upper nibble.

An optional blocking mode uses a per-channel mask. For each of the 30 voice channels, the mask picks whether the ABCD nibble comes from the registers or from the incoming timeslot-16 byte. The same registers can also carry common-channel signaling bytes, because they are inserted with the same snapshot timing.

Top module: `cas_ts16_inserter`

## Requirements
- R1: Every byte of a timeslot other than 16 leaves unchanged, exactly one clock after the valid cycle that carried it. `out_vld`, `out_frame_start` and `out_mf_start` repeat `in_vld`, `in_vld & in_frame_start` and `in_vld & in_mf_start` one clock later.
- R2: While control bit 0 (insert enable, register 0x30) is 0, the timeslot-16 byte also passes through unchanged, whatever the blocking-mode setting is.
- R3: When insert is enabled and control bit 1 (blocking mode) is 0, the timeslot-16 byte of frame f (f from 1 to 15) is the snapshot copy of register 0x40+f. That register holds channel f's ABCD bits in bits 7:4, with A at bit 7, and channel f+15's ABCD bits in bits 3:0.
- R4: When insert is enabled, the timeslot-16 byte of frame 0 is 0000 in bits 7:4, whatever was written to register 0x40. Bits 3:0 are the snapshot of register 0x40 bits 3:0: bit 2 is the remote multiframe alarm and bits 3, 1 and 0 are spare bits. Blocking mode has no effect on frame 0.
- R5: The snapshot is loaded from all sixteen registers only in a valid cycle that carries the multiframe strobe. A register write made during a multiframe first appears in the next one. When no write is made, each later multiframe repeats the same bytes.
- R6: In blocking mode, mask bit k selects the source of channel k+1. The mask bits are k = 8i+j, at bit j of register 0x31+i; for register 0x34 only bits 5:0 are used. A mask bit of 1 takes the nibble from the snapshot and 0 takes it from the incoming timeslot-16 byte. For frame f, bits 7:4 follow mask bit f-1 and bits 3:0 follow mask bit f+14.
- R7: Status register 0x35 bit 0 is set by every multiframe strobe and stays set until the status register is read. A read clears it, except that a strobe in the same cycle as the read wins and leaves it set. That read returns the value held before that cycle.
- R8: After reset, register 0x40 reads 0x0B, registers 0x41 to 0x4F read 0x00, and the control register, the mask and the status read 0. A read returns the written register value one clock after `hb_rd`, including bits 7:4 of register 0x40 as written.
- R9: The timeslot and frame position advance only on valid cycles. Idle cycles in the stream move neither the position nor `out_vld`, which is 0 one clock after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input byte valid |
| in_frame_start | input | 1 | Input byte is timeslot 0 of a frame |
| in_mf_start | input | 1 | Input byte is timeslot 0 of frame 0 of a multiframe |
| in_byte | input | 8 | Input timeslot byte |
| hb_wr | input | 1 | Host write strobe |
| hb_rd | input | 1 | Host read strobe |
| hb_addr | input | 8 | Host register address |
| hb_wdata | input | 8 | Host write data |
| hb_rdata | output | 8 | Host read data, valid the clock after `hb_rd` |
| out_vld | output | 1 | Output byte valid |
| out_byte | output | 8 | Output timeslot byte |
| out_frame_start | output | 1 | Delayed frame strobe |
| out_mf_start | output | 1 | Delayed multiframe strobe |

## Verification
Each multiframe uses a different seeded byte pattern, so a timeslot-16 byte that leaks from the wrong frame or from the wrong source does not match by chance. With insertion off, the test shows that the block can leave timeslot 16 untouched. With insertion on, a register 0x40 value that has bits 7:4 set separates the forced alignment word from the plain register copy. A write in the middle of a multiframe, followed by a multiframe with no writes, separates snapshot timing from live register reads. In blocking mode an uneven mask, with idle gaps inside a frame, checks the per-nibble source choice and the position tracking across stalls. A status read issued in the same cycle as a multiframe strobe checks that the set wins over the clear.

// File: rtl/cas_pkg.sv
package cas_pkg;

   typedef struct packed {
      logic blk_mode;
      logic ins_en;
   } cas_ctrl_t;

   localparam logic [7:0] CAS_SIG0_RST  = 8'h0B;
   localparam logic [7:0] CAS_SIGN_RST  = 8'h00;
   localparam logic [3:0] CAS_MFAS_WORD = 4'h0;

   function automatic logic [3:0] cas_pick(input logic use_reg,
                                           input logic [3:0] reg_nib,
                                           input logic [3:0] ser_nib);
      return use_reg ? reg_nib : ser_nib;
   endfunction

endpackage

// File: rtl/cas_ts_tracker.sv
// Timeslot / frame position from the strobes (R9)
module cas_ts_tracker #(
   parameter int TS_PER_FRAME  = 32,
   parameter int FRAMES_PER_MF = 16,
   localparam int TS_W = $clog2(TS_PER_FRAME),
   localparam int FR_W = $clog2(FRAMES_PER_MF)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_vld,
   input  logic            in_frame_start,
   input  logic            in_mf_start,
   output logic [TS_W-1:0] cur_ts,
   output logic [FR_W-1:0] cur_frame
);

   logic [TS_W-1:0] ts_nxt_q;
   logic [FR_W-1:0] fr_q;
   logic [FR_W-1:0] fr_inc;

   assign fr_inc = (fr_q == FR_W'(FRAMES_PER_MF - 1)) ? '0 : fr_q + 1'b1;

   always_comb begin
      cur_ts    = in_frame_start ? '0 : ts_nxt_q;
      cur_frame = in_mf_start ? '0 : (in_frame_start ? fr_inc : fr_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ts_nxt_q <= '0;
         fr_q     <= '0;
      end else if (in_vld) begin
         ts_nxt_q <= (cur_ts == TS_W'(TS_PER_FRAME - 1)) ? '0 : cur_ts + 1'b1;
         fr_q     <= cur_frame;
      end
   end

endmodule

// File: rtl/cas_host_regs.sv
// Host register file: signaling registers, control, mask, sticky status
module cas_host_regs
   import cas_pkg::*;
#(
   parameter int DW        = 8,
   parameter int AW        = 8,
   parameter int NUM_SIG   = 16,
   parameter int NUM_CH    = 30,
   parameter int SIG_BASE  = 'h40,
   parameter int CTRL_ADDR = 'h30,
   parameter int MASK_ADDR = 'h31,
   parameter int STAT_ADDR = 'h35,
   localparam int MASK_BYTES = (NUM_CH + DW - 1) / DW
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hb_wr,
   input  logic                  hb_rd,
   input  logic [AW-1:0]         hb_addr,
   input  logic [DW-1:0]         hb_wdata,
   input  logic                  mf_tick,
   output logic [DW-1:0]         hb_rdata,
   output logic [NUM_SIG*DW-1:0] sig_flat,
   output cas_ctrl_t             ctrl,
   output logic [NUM_CH-1:0]     mask,
   output logic                  mf_flag
);

   logic [DW-1:0]            sig_q [NUM_SIG];
   logic [MASK_BYTES*DW-1:0] mask_q;
   logic [DW-1:0]            rd_sel;
   logic                     stat_rd;

   assign stat_rd = hb_rd && (hb_addr == AW'(STAT_ADDR));

   for (genvar i = 0; i < NUM_SIG; i++) begin : g_sig
      always_ff @(posedge clk) begin
         if (!rst_n)
            sig_q[i] <= (i == 0) ? CAS_SIG0_RST : CAS_SIGN_RST;
         else if (hb_wr && hb_addr == AW'(SIG_BASE + i))
            sig_q[i] <= hb_wdata;
      end
      assign sig_flat[i*DW +: DW] = sig_q[i];
   end

   for (genvar b = 0; b < MASK_BYTES; b++) begin : g_mask
      always_ff @(posedge clk) begin
         if (!rst_n)
            mask_q[b*DW +: DW] <= '0;
         else if (hb_wr && hb_addr == AW'(MASK_ADDR + b))
            mask_q[b*DW +: DW] <= hb_wdata;
      end
   end
   assign mask = mask_q[NUM_CH-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctrl <= '0;
      else if (hb_wr && hb_addr == AW'(CTRL_ADDR))
         ctrl <= cas_ctrl_t'(hb_wdata[1:0]);
   end

   // R7: set has priority over clear-on-read
   always_ff @(posedge clk) begin
      if (!rst_n)
         mf_flag <= 1'b0;
      else if (mf_tick)
         mf_flag <= 1'b1;
      else if (stat_rd)
         mf_flag <= 1'b0;
   end

   always_comb begin
      rd_sel = '0;
      if (hb_addr == AW'(CTRL_ADDR))
         rd_sel = {{(DW-2){1'b0}}, ctrl};
      if (hb_addr == AW'(STAT_ADDR))
         rd_sel = {{(DW-1){1'b0}}, mf_flag};
      for (int b = 0; b < MASK_BYTES; b++)
         if (hb_addr == AW'(MASK_ADDR + b))
            rd_sel = mask_q[b*DW +: DW];
      for (int i = 0; i < NUM_SIG; i++)
         if (hb_addr == AW'(SIG_BASE + i))
            rd_sel = sig_q[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         hb_rdata <= '0;
      else if (hb_rd)
         hb_rdata <= rd_sel;
   end

endmodule

// File: rtl/cas_snapshot.sv
// Outgoing signaling buffer, reloaded only on the multiframe boundary (R5)
module cas_snapshot
   import cas_pkg::*;
#(
   parameter int DW      = 8,
   parameter int NUM_SIG = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [NUM_SIG*DW-1:0] sig_flat,
   output logic [NUM_SIG*DW-1:0] snap
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SIG; i++)
            snap[i*DW +: DW] <= (i == 0) ? CAS_SIG0_RST : CAS_SIGN_RST;
      end else if (load) begin
         snap <= sig_flat;
      end
   end

endmodule

// File: rtl/cas_ts16_mux.sv
// Timeslot-16 source selection and one-byte output stage
module cas_ts16_mux
   import cas_pkg::*;
#(
   parameter int DW            = 8,
   parameter int FRAMES_PER_MF = 16,
   parameter int NUM_CH        = 30,
   parameter int SIG_TS        = 16,
   parameter int TS_W          = 5,
   parameter bit FORCE_MFAS    = 1'b1,
   localparam int FR_W = $clog2(FRAMES_PER_MF)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_vld,
   input  logic                        in_frame_start,
   input  logic                        in_mf_start,
   input  logic [DW-1:0]               in_byte,
   input  logic [TS_W-1:0]             cur_ts,
   input  logic [FR_W-1:0]             cur_frame,
   input  cas_ctrl_t                   ctrl,
   input  logic [NUM_CH-1:0]           mask,
   input  logic [FRAMES_PER_MF*DW-1:0] snap,
   output logic                        out_vld,
   output logic [DW-1:0]               out_byte,
   output logic                        out_frame_start,
   output logic                        out_mf_start
);

   logic [DW-1:0]            snap_arr [FRAMES_PER_MF];
   logic [FRAMES_PER_MF-1:0] take_hi;
   logic [FRAMES_PER_MF-1:0] take_lo;
   logic [DW-1:0]            snap_byte;
   logic [3:0]               hi_nib;
   logic [3:0]               lo_nib;
   logic                     is_f0;
   logic [DW-1:0]            nxt_byte;

   for (genvar f = 0; f < FRAMES_PER_MF; f++) begin : g_sel
      assign snap_arr[f] = snap[f*DW +: DW];
      if (f == 0) begin : g_f0
         assign take_hi[f] = 1'b1;
         assign take_lo[f] = 1'b1;
      end else begin : g_fn
         assign take_hi[f] = mask[f-1];
         assign take_lo[f] = mask[f+FRAMES_PER_MF-2];
      end
   end

   assign snap_byte = snap_arr[cur_frame];
   assign is_f0     = (cur_frame == '0);

   assign lo_nib = cas_pick(!ctrl.blk_mode || take_lo[cur_frame],
                            snap_byte[3:0], in_byte[3:0]);

   if (FORCE_MFAS) begin : g_force
      assign hi_nib = is_f0 ? CAS_MFAS_WORD
                            : cas_pick(!ctrl.blk_mode || take_hi[cur_frame],
                                       snap_byte[7:4], in_byte[7:4]);
   end else begin : g_free
      assign hi_nib = cas_pick(!ctrl.blk_mode || take_hi[cur_frame],
                               snap_byte[7:4], in_byte[7:4]);
   end

   assign nxt_byte = (ctrl.ins_en && cur_ts == TS_W'(SIG_TS)) ? {hi_nib, lo_nib} : in_byte;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld         <= 1'b0;
         out_byte        <= '0;
         out_frame_start <= 1'b0;
         out_mf_start    <= 1'b0;
      end else begin
         out_vld         <= in_vld;
         out_frame_start <= in_vld && in_frame_start;
         out_mf_start    <= in_vld && in_mf_start;
         if (in_vld)
            out_byte <= nxt_byte;
      end
   end

endmodule

// File: rtl/cas_ts16_inserter.sv
module cas_ts16_inserter
   import cas_pkg::*;
#(
   parameter int DW            = 8,
   parameter int AW            = 8,
   parameter int TS_PER_FRAME  = 32,
   parameter int FRAMES_PER_MF = 16,
   parameter int NUM_CH        = 30,
   parameter int SIG_TS        = 16,
   parameter int SIG_BASE      = 'h40,
   parameter int CTRL_ADDR     = 'h30,
   parameter int MASK_ADDR     = 'h31,
   parameter int STAT_ADDR     = 'h35,
   parameter bit FORCE_MFAS    = 1'b1,
   localparam int TS_W   = $clog2(TS_PER_FRAME),
   localparam int FR_W   = $clog2(FRAMES_PER_MF),
   localparam int SNAP_W = FRAMES_PER_MF * DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic          in_frame_start,
   input  logic          in_mf_start,
   input  logic [DW-1:0] in_byte,
   input  logic          hb_wr,
   input  logic          hb_rd,
   input  logic [AW-1:0] hb_addr,
   input  logic [DW-1:0] hb_wdata,
   output logic [DW-1:0] hb_rdata,
   output logic          out_vld,
   output logic [DW-1:0] out_byte,
   output logic          out_frame_start,
   output logic          out_mf_start
);

   if (DW != 8) begin : g_bad_dw
      $error("cas_ts16_inserter: DW must be 8");
   end
   if (NUM_CH != 2 * (FRAMES_PER_MF - 1)) begin : g_bad_ch
      $error("cas_ts16_inserter: NUM_CH must equal 2*(FRAMES_PER_MF-1)");
   end
   if (SIG_TS <= 0 || SIG_TS >= TS_PER_FRAME) begin : g_bad_ts
      $error("cas_ts16_inserter: SIG_TS out of range");
   end
   if ((1 << FR_W) != FRAMES_PER_MF) begin : g_bad_fr
      $error("cas_ts16_inserter: FRAMES_PER_MF must be a power of two");
   end

   logic [TS_W-1:0]   cur_ts;
   logic [FR_W-1:0]   cur_frame;
   logic [SNAP_W-1:0] sig_flat;
   logic [SNAP_W-1:0] snap;
   logic [NUM_CH-1:0] mask;
   cas_ctrl_t         ctrl_q;
   logic              mf_flag;
   logic              mf_tick;

   assign mf_tick = in_vld && in_mf_start;

   cas_ts_tracker #(
      .TS_PER_FRAME (TS_PER_FRAME),
      .FRAMES_PER_MF(FRAMES_PER_MF)
   ) u_track (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_vld        (in_vld),
      .in_frame_start(in_frame_start),
      .in_mf_start   (in_mf_start),
      .cur_ts        (cur_ts),
      .cur_frame     (cur_frame)
   );

   cas_host_regs #(
      .DW       (DW),
      .AW       (AW),
      .NUM_SIG  (FRAMES_PER_MF),
      .NUM_CH   (NUM_CH),
      .SIG_BASE (SIG_BASE),
      .CTRL_ADDR(CTRL_ADDR),
      .MASK_ADDR(MASK_ADDR),
      .STAT_ADDR(STAT_ADDR)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .hb_wr   (hb_wr),
      .hb_rd   (hb_rd),
      .hb_addr (hb_addr),
      .hb_wdata(hb_wdata),
      .mf_tick (mf_tick),
      .hb_rdata(hb_rdata),
      .sig_flat(sig_flat),
      .ctrl    (ctrl_q),
      .mask    (mask),
      .mf_flag (mf_flag)
   );

   cas_snapshot #(
      .DW     (DW),
      .NUM_SIG(FRAMES_PER_MF)
   ) u_snap (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (mf_tick),
      .sig_flat(sig_flat),
      .snap    (snap)
   );

   cas_ts16_mux #(
      .DW           (DW),
      .FRAMES_PER_MF(FRAMES_PER_MF),
      .NUM_CH       (NUM_CH),
      .SIG_TS       (SIG_TS),
      .TS_W         (TS_W),
      .FORCE_MFAS   (FORCE_MFAS)
   ) u_mux (
      .clk            (clk),
      .rst_n          (rst_n),
      .in_vld         (in_vld),
      .in_frame_start (in_frame_start),
      .in_mf_start    (in_mf_start),
      .in_byte        (in_byte),
      .cur_ts         (cur_ts),
      .cur_frame      (cur_frame),
      .ctrl           (ctrl_q),
      .mask           (mask),
      .snap           (snap),
      .out_vld        (out_vld),
      .out_byte       (out_byte),
      .out_frame_start(out_frame_start),
      .out_mf_start   (out_mf_start)
   );

endmodule

// File: rtl/cas_ts16_inserter_chk.sv
module cas_ts16_inserter_chk #(
   parameter int DW     = 8,
   parameter int TS_W   = 5,
   parameter int FR_W   = 4,
   parameter int SIG_TS = 16,
   parameter int SNAP_W = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_vld,
   input logic              in_frame_start,
   input logic              in_mf_start,
   input logic [DW-1:0]     in_byte,
   input logic              hb_rd,
   input logic              out_vld,
   input logic [DW-1:0]     out_byte,
   input logic              out_frame_start,
   input logic              ins_en,
   input logic [TS_W-1:0]   cur_ts,
   input logic [FR_W-1:0]   cur_frame,
   input logic              mf_flag,
   input logic [SNAP_W-1:0] snap
);

   AST_VLD_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld); // R1
   AST_STROBE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_frame_start) |=> out_frame_start); // R1
   AST_PASS_OTHER_TS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && cur_ts != TS_W'(SIG_TS)) |=> out_byte == $past(in_byte)); // R1
   AST_PASS_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !ins_en) |=> out_byte == $past(in_byte)); // R2
   AST_MFAS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && ins_en && cur_ts == TS_W'(SIG_TS) && cur_frame == '0)
      |=> out_byte[DW-1:DW-4] == 4'h0); // R4
   AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_vld && in_mf_start) |=> $stable(snap)); // R5
   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_mf_start) |=> mf_flag); // R7
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mf_flag && !hb_rd) |=> mf_flag); // R7

endmodule

bind cas_ts16_inserter cas_ts16_inserter_chk #(
   .DW    (DW),
   .TS_W  (TS_W),
   .FR_W  (FR_W),
   .SIG_TS(SIG_TS),
   .SNAP_W(SNAP_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .in_vld         (in_vld),
   .in_frame_start (in_frame_start),
   .in_mf_start    (in_mf_start),
   .in_byte        (in_byte),
   .hb_rd          (hb_rd),
   .out_vld        (out_vld),
   .out_byte       (out_byte),
   .out_frame_start(out_frame_start),
   .ins_en         (ctrl_q.ins_en),
   .cur_ts         (cur_ts),
   .cur_frame      (cur_frame),
   .mf_flag        (mf_flag),
   .snap           (snap)
);

// File: tb/cas_ts16_inserter_bench.sv
module cas_ts16_inserter_bench;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       in_vld, in_frame_start, in_mf_start;
   logic [7:0] in_byte;
   logic       hb_wr, hb_rd;
   logic [7:0] hb_addr, hb_wdata, hb_rdata;
   logic       out_vld, out_frame_start, out_mf_start;
   logic [7:0] out_byte;

   always #5 clk = ~clk;

   cas_ts16_inserter u_cas_ts16_inserter (
      .clk(clk), .rst_n(rst_n),
      .in_vld(in_vld), .in_frame_start(in_frame_start), .in_mf_start(in_mf_start),
      .in_byte(in_byte),
      .hb_wr(hb_wr), .hb_rd(hb_rd), .hb_addr(hb_addr), .hb_wdata(hb_wdata),
      .hb_rdata(hb_rdata),
      .out_vld(out_vld), .out_byte(out_byte),
      .out_frame_start(out_frame_start), .out_mf_start(out_mf_start)
   );

   int n_chk  = 0;
   int n_fail = 0;

   logic [7:0]  host_m [16];
   logic [7:0]  snap_m [16];
   logic        en_m, blk_m;
   logic [29:0] mask_m;

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input logic [7:0] seed, input int fr, input int ts);
      return seed ^ 8'(fr * 16 + ts * 7);
   endfunction

   function automatic logic [7:0] exp_ts16(input int fr, input logic [7:0] b);
      logic [7:0] r;
      r = snap_m[fr];
      if (fr == 0) return {4'h0, r[3:0]};
      if (!blk_m) return r;
      return {mask_m[fr-1] ? r[7:4] : b[7:4], mask_m[fr+14] ? r[3:0] : b[3:0]};
   endfunction

   // all tasks start and end at a falling edge
   task automatic stream_byte(input logic [7:0] b, input logic fs, input logic ms,
                              input logic [7:0] exp, input string tag);
      in_vld = 1'b1; in_byte = b; in_frame_start = fs; in_mf_start = ms;
      @(posedge clk); @(negedge clk);
      in_vld = 1'b0; in_frame_start = 1'b0; in_mf_start = 1'b0;
      chk(tag, out_byte, exp);
      chk("R1", {7'd0, out_vld}, 8'd1);
      chk("R1", {7'd0, out_frame_start}, {7'd0, fs});
      chk("R1", {7'd0, out_mf_start}, {7'd0, ms});
   endtask

   task automatic idle_cycle();
      @(posedge clk); @(negedge clk);
      chk("R9", {7'd0, out_vld}, 8'd0);
   endtask

   task automatic host_write(input logic [7:0] a, input logic [7:0] d);
      hb_wr = 1'b1; hb_addr = a; hb_wdata = d;
      @(posedge clk); @(negedge clk);
      hb_wr = 1'b0;
      if (a >= 8'h40 && a <= 8'h4F) host_m[a - 8'h40] = d;
      if (a == 8'h30) begin en_m = d[0]; blk_m = d[1]; end
      if (a == 8'h31) mask_m[7:0]   = d;
      if (a == 8'h32) mask_m[15:8]  = d;
      if (a == 8'h33) mask_m[23:16] = d;
      if (a == 8'h34) mask_m[29:24] = d[5:0];
   endtask

   task automatic host_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
      hb_rd = 1'b1; hb_addr = a;
      @(posedge clk); @(negedge clk);
      hb_rd = 1'b0;
      chk(tag, hb_rdata, exp);
   endtask

   task automatic send_frame(input int fr, input logic [7:0] seed, input string tag16,
                             input bit gap, input bit rd_at_mf);
      for (int ts = 0; ts < 32; ts++) begin
         logic [7:0] b, e;
         string t;
         b = pat(seed, fr, ts);
         if (fr == 0 && ts == 0) for (int i = 0; i < 16; i++) snap_m[i] = host_m[i];
         if (ts == 16 && en_m) begin
            e = exp_ts16(fr, b);
            t = (tag16 != "") ? tag16 : (fr == 0 ? "R4" : (blk_m ? "R6" : "R3"));
         end else begin
            e = b;
            t = (ts == 16) ? "R2" : "R1";
         end
         if (rd_at_mf && fr == 0 && ts == 0) begin
            hb_rd = 1'b1; hb_addr = 8'h35;
         end
         stream_byte(b, ts == 0, fr == 0 && ts == 0, e, t);
         if (rd_at_mf && fr == 0 && ts == 0) begin
            hb_rd = 1'b0;
            chk("R7", hb_rdata, 8'h00);
         end
         if (gap && ts == 10) idle_cycle();
      end
   endtask

   task automatic send_mf(input logic [7:0] seed, input string tag16, input bit gap);
      for (int fr = 0; fr < 16; fr++) send_frame(fr, seed, tag16, gap, 1'b0);
   endtask

   task automatic t_reset();
      chk("R8", {7'd0, out_vld}, 8'd0);
      host_read(8'h40, 8'h0B, "R8");
      host_read(8'h4F, 8'h00, "R8");
      host_read(8'h30, 8'h00, "R8");
      host_read(8'h33, 8'h00, "R8");
      host_read(8'h35, 8'h00, "R8");
   endtask

   task automatic t_disabled();
      host_write(8'h47, 8'h6B);
      send_mf(8'h3C, "", 1'b0);
   endtask

   task automatic t_flag();
      host_read(8'h35, 8'h01, "R7");
      host_read(8'h35, 8'h00, "R7");
      for (int fr = 0; fr < 16; fr++) send_frame(fr, 8'h77, "", 1'b0, fr == 0);
      host_read(8'h35, 8'h01, "R7");
      host_read(8'h35, 8'h00, "R7");
   endtask

   task automatic t_insert();
      host_write(8'h40, 8'hF5);
      for (int i = 1; i < 16; i++) host_write(8'(8'h40 + i), 8'(i * 17) ^ 8'h96);
      host_write(8'h30, 8'h01);
      host_read(8'h40, 8'hF5, "R8");
      host_read(8'h30, 8'h01, "R8");
      send_mf(8'h5A, "", 1'b0);
   endtask

   task automatic t_hold();
      for (int fr = 0; fr < 8; fr++) send_frame(fr, 8'h21, "", 1'b0, 1'b0);
      host_write(8'h4C, 8'h9C);
      host_write(8'h40, 8'h0E);
      for (int fr = 8; fr < 16; fr++) send_frame(fr, 8'h21, "R5", 1'b0, 1'b0);
      send_mf(8'h44, "R5", 1'b0);
      send_mf(8'h88, "R5", 1'b0);
   endtask

   task automatic t_block();
      host_write(8'h31, 8'hA5);
      host_write(8'h32, 8'h3C);
      host_write(8'h33, 8'h0F);
      host_write(8'h34, 8'h2A);
      host_write(8'h30, 8'h03);
      send_mf(8'hC3, "", 1'b1);
   endtask

   task automatic t_off_again();
      host_write(8'h30, 8'h02);
      send_mf(8'hE1, "", 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_vld = 1'b0; in_frame_start = 1'b0; in_mf_start = 1'b0;
      in_byte = '0; hb_wr = 1'b0; hb_rd = 1'b0; hb_addr = '0; hb_wdata = '0;
      en_m = 1'b0; blk_m = 1'b0; mask_m = '0;
      for (int i = 0; i < 16; i++) host_m[i] = (i == 0) ? 8'h0B : 8'h00;
      for (int i = 0; i < 16; i++) snap_m[i] = host_m[i];
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_disabled();
      t_flag();
      t_insert();
      t_hold();
      t_block();
      t_off_again();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule